// File: doc/BRIEF.md
# Registered 6-and-6 weighted parallel counter

This block adds up twelve single-bit inputs in one pipeline step and returns the total as a 5-bit binary count. In its default shape, six of the inputs have weight 1 and six have weight 4, and no input has weight 2. Each input column first passes through a two-full-adder reduction stage. The reduced bits then enter a four-position ripple-carry chain built from XOR gates and carry multiplexers. One raw input per populated column is fed directly into that chain as its second operand. The carry into the chain is a constant zero and never carries a counter input.

A build-time option selects a second shape with the same depth. In that shape, five inputs have weight 1, two have weight 2, three have weight 4 and one has weight 8. The data moves as a stream. Input words are taken with a valid/ready handshake, and each result sits in a single output register until the consumer takes it. Back-pressure works as follows: while a result is held and `res_ready` is low, `req_ready` is low, and the held count and its valid flag do not change. A word is transferred on a rising edge where `req_valid` and `req_ready` are both high. A result is consumed on an edge where `res_valid` and `res_ready` are both high.

Top module: `wpc_counter`

## Requirements
- R1: With the default shape, the count equals the number of ones in `grp_a` plus four times the number of ones in `grp_b`. Every bit of `grp_a` has weight 1 and every bit of `grp_b` has weight 4.
- R2: With the alternative shape, the count is the sum of four terms: the ones in `grp_a[4:0]`, twice the ones in `grp_b[1:0]`, four times the ones in `grp_b[4:2]`, and eight times `grp_b[5]`. Bit `grp_a[5]` has no effect on the count.
- R3: A valid count never goes above 30 in the default shape or 29 in the alternative shape. Both maxima are reached when every input is one.
- R4: While `rst_n` is low, and on the first edge after it is released with no transfer, `res_valid` is 0.
- R5: An accepted input word produces `res_valid` = 1 and its count on the very next rising edge, so the latency is one cycle.
- R6: `req_ready` is high exactly when no result is held or the held result is being taken in the same cycle. While a result is held and `res_ready` is low, `res_valid` and `res_count` stay unchanged, and an offered word is not taken.
- R7: When a held result is taken and no new word is accepted on the same edge, `res_valid` falls to 0.
- R8: With `res_ready` held high, a new word is accepted on every cycle. Each result lines up with the word that was offered one cycle earlier.
- R9: The chain carry-in is fixed at zero, so an all-zero input word gives a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | An input word is offered |
| req_ready | output | 1 | An input word can be taken this cycle |
| grp_a | input | 6 | Low-weight input group |
| grp_b | input | 6 | High-weight input group (weights depend on shape) |
| res_valid | output | 1 | `res_count` holds a result |
| res_ready | input | 1 | The consumer takes the result this cycle |
| res_count | output | 5 | Weighted count of the accepted word |

## Verification
The assertions assume two things about the inputs after reset. First, `grp_a` and `grp_b` carry no unknown bits whenever `req_valid` is high. Second, the handshake inputs are always 0 or 1. The combinational checks are skipped while any operand is still unknown. The bench drives every input to a known value at time zero, and it changes inputs only on the falling clock edge, so every sampled word is fully defined and stable around the rising edge.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  typedef enum logic [0:0] {
    SHAPE_606  = 1'b0,
    SHAPE_1325 = 1'b1
  } wpc_shape_e;

  localparam int unsigned GRP_W     = 6;
  localparam int unsigned CHAIN_LEN = 4;
  localparam int unsigned SUM_W     = CHAIN_LEN + 1;
  localparam int unsigned CELL_IN   = 5;

  typedef struct packed {
    logic [CHAIN_LEN-1:0] op_a;
    logic [CHAIN_LEN-1:0] op_b;
  } chain_ops_t;

  // {carry, sum} of three equal-weight bits
  function automatic logic [1:0] fa3(input logic x, input logic y, input logic z);
    fa3 = {(x & y) | (x & z) | (y & z), x ^ y ^ z};
  endfunction

  function automatic int unsigned max_total(input wpc_shape_e s);
    max_total = (s == SHAPE_606) ? 30 : 29;
  endfunction
endpackage

// File: rtl/wpc_pair_cell.sv
module wpc_pair_cell
  import wpc_pkg::*;
(
  input  logic [CELL_IN-1:0] bits,
  output logic               sum,
  output logic               c_lo,
  output logic               c_hi
);
  logic [1:0] first;
  logic [1:0] second;

  always_comb begin
    first  = fa3(bits[0], bits[1], bits[2]);
    second = fa3(first[0], bits[3], bits[4]);
    sum    = second[0];
    c_lo   = first[1];
    c_hi   = second[1];
  end

  // R1/R2: the pair of adders preserves the column's population
  always_comb begin
    if (!$isunknown(bits)) begin
      p_pair_count_r1: assert (int'(sum) + 2 * (int'(c_lo) + int'(c_hi)) == $countones(bits))
        else $error("pair cell lost a bit");
    end
  end
endmodule

// File: rtl/wpc_carry_chain.sv
module wpc_carry_chain
  import wpc_pkg::*;
#(
  parameter int unsigned N = CHAIN_LEN
) (
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  output logic [N:0]   total
);
  logic [N:0]   carry;
  logic [N-1:0] prop;
  logic [N-1:0] sum_bit;

  assign carry[0] = 1'b0;  // R9: carry-in never used as an input

  for (genvar i = 0; i < N; i++) begin : g_pos
    assign prop[i]     = op_a[i] ^ op_b[i];
    assign sum_bit[i]  = prop[i] ^ carry[i];
    assign carry[i+1]  = prop[i] ? carry[i] : op_b[i];
  end

  assign total = {carry[N], sum_bit};

  // R1: ripple chain matches binary addition of its two operands
  always_comb begin
    if (!$isunknown({op_a, op_b})) begin
      p_chain_sum_r1: assert (total == ({1'b0, op_a} + {1'b0, op_b}))
        else $error("carry chain mismatch");
    end
  end
endmodule

// File: rtl/wpc_column_map.sv
module wpc_column_map
  import wpc_pkg::*;
#(
  parameter wpc_shape_e SHAPE = SHAPE_606
) (
  input  logic [GRP_W-1:0] grp_a,
  input  logic [GRP_W-1:0] grp_b,
  output chain_ops_t       ops
);
  if (SHAPE == SHAPE_606) begin : g_606
    logic s_w1, c1_w1, c2_w1;
    logic s_w4, c1_w4, c2_w4;

    wpc_pair_cell u_cell_w1 (.bits(grp_a[CELL_IN-1:0]), .sum(s_w1), .c_lo(c1_w1), .c_hi(c2_w1));
    wpc_pair_cell u_cell_w4 (.bits(grp_b[CELL_IN-1:0]), .sum(s_w4), .c_lo(c1_w4), .c_hi(c2_w4));

    // positions: 0 -> weight 1, 1 -> weight 2, 2 -> weight 4, 3 -> weight 8
    assign ops.op_a = {c1_w4, s_w4, c1_w1, s_w1};
    assign ops.op_b = {c2_w4, grp_b[GRP_W-1], c2_w1, grp_a[GRP_W-1]};
  end else begin : g_1325
    logic       s_w1, c1_w1, c2_w1;
    logic [1:0] fa_w2;
    logic [1:0] fa_w4;

    wpc_pair_cell u_cell_w1 (.bits(grp_a[CELL_IN-1:0]), .sum(s_w1), .c_lo(c1_w1), .c_hi(c2_w1));

    assign fa_w2 = fa3(c1_w1, c2_w1, grp_b[0]);
    assign fa_w4 = fa3(fa_w2[1], grp_b[2], grp_b[3]);

    assign ops.op_a = {fa_w4[1], fa_w4[0], fa_w2[0], s_w1};
    assign ops.op_b = {grp_b[5], grp_b[4], grp_b[1], 1'b0};
  end
endmodule

// File: rtl/wpc_counter.sv
module wpc_counter
  import wpc_pkg::*;
#(
  parameter wpc_shape_e SHAPE = SHAPE_606
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [GRP_W-1:0] grp_a,
  input  logic [GRP_W-1:0] grp_b,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [SUM_W-1:0] res_count
);
  localparam int unsigned MAX_COUNT = max_total(SHAPE);

  chain_ops_t       ops;
  logic [SUM_W-1:0] chain_total;
  logic             accept;
  logic             valid_q;
  logic [SUM_W-1:0] count_q;

  wpc_column_map #(.SHAPE(SHAPE)) u_map (
    .grp_a (grp_a),
    .grp_b (grp_b),
    .ops   (ops)
  );

  wpc_carry_chain #(.N(CHAIN_LEN)) u_chain (
    .op_a  (ops.op_a),
    .op_b  (ops.op_b),
    .total (chain_total)
  );

  assign req_ready = !valid_q || res_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      count_q <= '0;
    end else if (accept) begin
      valid_q <= 1'b1;
      count_q <= chain_total;
    end else if (res_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign res_valid = valid_q;
  assign res_count = count_q;

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (int'(res_count) <= MAX_COUNT));

  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> res_valid);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_count)));

  p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && !req_valid) |=> !res_valid);

  if (SHAPE == SHAPE_606) begin : g_chk_606
    p_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=>
        (int'(res_count) == $past($countones(grp_a)) + 4 * $past($countones(grp_b))));
  end else begin : g_chk_1325
    p_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=>
        (int'(res_count) == $past($countones(grp_a[4:0])) + 2 * $past($countones(grp_b[1:0]))
                          + 4 * $past($countones(grp_b[4:2])) + 8 * $past(int'(grp_b[5]))));
  end
endmodule

// File: tb/wpc_counter_test.sv
module wpc_counter_test;
  import wpc_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       res_ready = 1'b0;
  logic [5:0] grp_a = '0;
  logic [5:0] grp_b = '0;
  logic       req_ready, req_ready_alt;
  logic       res_valid, res_valid_alt;
  logic [4:0] res_count, res_count_alt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] rng = 32'h1234_5678;

  always #2.5 clk = ~clk;

  wpc_counter #(.SHAPE(SHAPE_606)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .grp_a(grp_a), .grp_b(grp_b), .res_valid(res_valid), .res_ready(res_ready),
    .res_count(res_count)
  );

  wpc_counter #(.SHAPE(SHAPE_1325)) uut_alt (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready_alt),
    .grp_a(grp_a), .grp_b(grp_b), .res_valid(res_valid_alt), .res_ready(res_ready),
    .res_count(res_count_alt)
  );

  function automatic int ones(input logic [5:0] v);
    int n = 0;
    for (int i = 0; i < 6; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic int model_main(input logic [5:0] a, input logic [5:0] b);
    return ones(a) + 4 * ones(b);
  endfunction

  function automatic int model_alt(input logic [5:0] a, input logic [5:0] b);
    return ones({1'b0, a[4:0]}) + 2 * ones({4'b0, b[1:0]}) + 4 * ones({3'b0, b[4:2]}) + 8 * int'(b[5]);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic next_rand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
  endtask

  // offer one word with the consumer ready, check both shapes one cycle later
  task automatic send_one(input logic [5:0] a, input logic [5:0] b, input string tag);
    @(negedge clk);
    res_ready = 1'b1;
    req_valid = 1'b1;
    grp_a = a;
    grp_b = b;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R5 valid"}, int'(res_valid), 1);
    check({tag, " R1 count"}, int'(res_count), model_main(a, b));
    check({tag, " R2 count"}, int'(res_count_alt), model_alt(a, b));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R4 valid in reset", int'(res_valid), 0);
    check("R4 alt valid in reset", int'(res_valid_alt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4 valid after release", int'(res_valid), 0);
    check("R6 ready when empty", int'(req_ready), 1);
  endtask

  task automatic t_extremes();
    send_one(6'h00, 6'h00, "zero R9");
    send_one(6'h3F, 6'h3F, "ones");
    check("R3 max main", int'(res_count), 30);
    check("R3 max alt", int'(res_count_alt), 29);
  endtask

  task automatic t_walking();
    for (int i = 0; i < 6; i++) begin
      send_one(6'(1 << i), 6'h00, "walk a");
      send_one(6'h00, 6'(1 << i), "walk b");
    end
  endtask

  task automatic t_alt_ignore();
    send_one(6'h20, 6'h00, "R2 ignore");
    check("R2 grp_a[5] ignored", int'(res_count_alt), 0);
    send_one(6'h3F, 6'h15, "R2 mix");
    send_one(6'h1F, 6'h15, "R2 mix no a5");
  endtask

  task automatic t_random();
    for (int i = 0; i < 40; i++) begin
      next_rand();
      send_one(rng[5:0], rng[13:8], "random");
    end
  endtask

  task automatic t_backpressure();
    logic [5:0] a1 = 6'h2B, b1 = 6'h11, a2 = 6'h05, b2 = 6'h3C;
    @(negedge clk);
    res_ready = 1'b0;
    req_valid = 1'b1;
    grp_a = a1;
    grp_b = b1;
    @(negedge clk);
    check("R5 bp valid", int'(res_valid), 1);
    check("R6 ready low while full", int'(req_ready), 0);
    grp_a = a2;
    grp_b = b2;
    @(negedge clk);
    check("R6 held valid", int'(res_valid), 1);
    check("R6 held count", int'(res_count), model_main(a1, b1));
    @(negedge clk);
    check("R6 still held", int'(res_count), model_main(a1, b1));
    check("R6 ready when draining", int'(req_ready), 0);
    res_ready = 1'b1;
    #1;
    check("R6 ready follows consumer", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    check("R6 second word after release", int'(res_count), model_main(a2, b2));
    check("R6 second valid", int'(res_valid), 1);
    @(negedge clk);
    check("R7 valid drops", int'(res_valid), 0);
  endtask

  task automatic t_stream();
    logic [5:0] pa = '0, pb = '0;
    @(negedge clk);
    res_ready = 1'b1;
    for (int i = 0; i < 10; i++) begin
      if (i > 0) begin
        check("R8 stream valid", int'(res_valid), 1);
        check("R8 stream count", int'(res_count), model_main(pa, pb));
        check("R8 stream ready", int'(req_ready), 1);
      end
      next_rand();
      pa = rng[5:0];
      pb = rng[21:16];
      req_valid = 1'b1;
      grp_a = pa;
      grp_b = pb;
      @(negedge clk);
    end
    req_valid = 1'b0;
    check("R8 last count", int'(res_count), model_main(pa, pb));
    @(negedge clk);
    check("R7 stream end", int'(res_valid), 0);
  endtask

  initial begin
    t_reset();
    t_extremes();
    t_walking();
    t_alt_ignore();
    t_random();
    t_backpressure();
    t_stream();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule